// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

The block runs one integer multiply or divide at a time. It works on 32-bit or 64-bit operands, treated as signed or unsigned. A multiply leaves its full double-width product split across a high and a low result register. A divide leaves the remainder in the high register and the quotient in the low register. The unit has no pipeline, so a second operation waits until the first one completes.

A caller drives an operation code and two operands with a one-cycle start strobe while the unit is idle. The unit raises busy on the next cycle. The results appear together with a one-cycle done pulse. Multiplies take a fixed number of cycles for each operand width. Divides skip leading zero quotient digits, so their cost grows with the number of quotient bits that have to be produced.

Top module: `muldiv_iter`

## Requirements
- R1: In reset and in the first idle cycle after reset, busy, done and both result words are zero.
- R2: A start is taken only when busy is low, including the cycle in which done pulses. A start while busy changes neither the timing nor the results of the operation in flight.
- R3: Busy is high from the cycle after acceptance until the cycle before done. Busy is low in the done cycle. Done lasts exactly one cycle.
- R4: The operation code is {width, signedness, kind}: bit 2 set means 64-bit, bit 1 set means signed, bit 0 set means divide. A 32-bit multiply reaches done 4 cycles after the accepting edge. It uses the low 32 bits of each operand, and the high and low halves of its 64-bit product are each sign-extended to 64 bits into hi and lo.
- R5: A 64-bit multiply reaches done 6 cycles after acceptance. Hi:lo holds the full 128-bit product.
- R6: In signed operations the operands are read as two's complement (32-bit operands are sign-extended). In unsigned operations the operands are read as magnitudes (32-bit operands are zero-extended).
- R7: A divide returns the quotient, truncated toward zero, in lo and the remainder, which takes the sign of the dividend, in hi. Both wrap to the operation width, and 32-bit results are sign-extended.
- R8: A divide by a non-zero divisor reaches done L cycles after acceptance. L = 21 + ((k-1)*52+31)/63 using integer division, clamped to 73. k is the bit index of the dividend magnitude's leading one minus that of the divisor magnitude, plus one. k is 1 when the dividend is zero or smaller in leading-one position.
- R9: A divide by zero reaches done after 21 cycles. Lo is all ones and hi is the extended dividend (sign-extended from bit 31 for 32-bit operations).
- R10: Hi and lo change only in a done cycle and otherwise keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken when busy is low |
| op_i | input | 3 | {64-bit, signed, divide} |
| a_i | input | 64 | Multiplicand or dividend |
| b_i | input | 64 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result pulse |
| hi_o | output | 64 | Product high half or remainder |
| lo_o | output | 64 | Product low half or quotient |

## Verification
The hardest case to reach is a new start landing in the very cycle done pulses. This tests that acceptance keys on busy alone and that the next operation's timing begins cleanly. The stimulus chains each operation from the done cycle of the one before. Long divides need dividends whose leading one sits far above the divisor's. A 2^63 dividend over 1 gives the 73-cycle extreme, and random operands are shifted right by random amounts to cover the range of k between the extremes. Signed minimum over minus one, zero divisors and starts asserted during busy are driven on purpose.

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int CHUNK       = 16,
  parameter int MUL_LAT_32  = 4,
  parameter int MUL_LAT_64  = 6,
  parameter int DIV_LAT_MIN = 21,
  parameter int DIV_LAT_MAX = 73
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  op_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [63:0] hi_o,
  output logic [63:0] lo_o
);
  localparam int W    = 64;
  localparam int NCH  = W / CHUNK;
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SPAN = DIV_LAT_MAX - DIV_LAT_MIN;

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [6:0] msb_of(input logic [63:0] v);
    logic [6:0] p;
    p = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) p = 7'(i);
    return p;
  endfunction

  logic          busy_q, done_q;
  logic [6:0]    cnt, steps;
  logic [IW-1:0] idx;
  logic          div_q, wide_q, negp_q, negr_q, dz_q;
  logic [63:0]   a_q, d_q, ea_q;
  logic [127:0]  acc;
  logic [63:0]   hi_q, lo_q;

  logic [63:0] ea, eb, ma, mb;
  logic        na, nb;
  logic [6:0]  pa, pb, kq, dlat, mlat;
  logic [12:0] span;
  logic [6:0]  draw;

  assign ea = op_i[2] ? a_i : (op_i[1] ? sx32(a_i[31:0]) : {32'b0, a_i[31:0]});
  assign eb = op_i[2] ? b_i : (op_i[1] ? sx32(b_i[31:0]) : {32'b0, b_i[31:0]});
  assign na = op_i[1] & ea[63];
  assign nb = op_i[1] & eb[63];
  assign ma = na ? (64'd0 - ea) : ea;
  assign mb = nb ? (64'd0 - eb) : eb;
  assign pa = msb_of(ma);
  assign pb = msb_of(mb);
  assign kq = (ma != 64'd0 && pa >= pb) ? (pa - pb + 7'd1) : 7'd1;
  assign span = 13'(kq - 7'd1) * 13'(SPAN) + 13'd31;
  assign draw = 7'(DIV_LAT_MIN + int'(span) / (W - 1));
  assign dlat = (mb == 64'd0) ? 7'(DIV_LAT_MIN)
              : (draw > 7'(DIV_LAT_MAX) ? 7'(DIV_LAT_MAX) : draw);
  assign mlat = op_i[2] ? 7'(MUL_LAT_64) : 7'(MUL_LAT_32);

  logic [127:0] prod;
  logic [63:0]  quo, rem, rhi, rlo;

  assign prod = negp_q ? (128'd0 - acc) : acc;
  assign quo  = dz_q ? '1 : (negp_q ? (64'd0 - acc[63:0]) : acc[63:0]);
  assign rem  = dz_q ? ea_q : (negr_q ? (64'd0 - a_q) : a_q);

  always_comb begin
    if (div_q) begin
      rhi = rem;
      rlo = quo;
    end else begin
      rhi = prod[127:64];
      rlo = prod[63:0];
    end
    if (!wide_q) begin
      rhi = sx32(div_q ? rem[31:0] : prod[63:32]);
      rlo = sx32(div_q ? quo[31:0] : prod[31:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      steps  <= '0;
      idx    <= '0;
      div_q  <= 1'b0;
      wide_q <= 1'b0;
      negp_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
      a_q    <= '0;
      d_q    <= '0;
      ea_q   <= '0;
      acc    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cnt <= cnt - 7'd1;
        if (steps != 7'd0) begin
          steps <= steps - 7'd1;
          if (div_q) begin
            if (a_q >= d_q) begin
              a_q <= a_q - d_q;
              acc <= {acc[126:0], 1'b1};
            end else begin
              acc <= {acc[126:0], 1'b0};
            end
            d_q <= d_q >> 1;
          end else begin
            acc <= acc + ((128'(a_q) * 128'(d_q[int'(idx)*CHUNK +: CHUNK])) << (int'(idx)*CHUNK));
            idx <= idx + 1'b1;
          end
        end
        if (cnt == 7'd1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= rhi;
          lo_q   <= rlo;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        div_q  <= op_i[0];
        wide_q <= op_i[2];
        negp_q <= na ^ nb;
        negr_q <= na;
        dz_q   <= op_i[0] && (mb == 64'd0);
        ea_q   <= ea;
        a_q    <= ma;
        acc    <= '0;
        idx    <= '0;
        if (op_i[0]) begin
          cnt   <= dlat;
          steps <= kq;
          d_q   <= mb << (kq - 7'd1);
        end else begin
          cnt   <= mlat;
          steps <= op_i[2] ? 7'(NCH) : 7'(NCH / 2);
          d_q   <= mb;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  // R3
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

// File: tb/tb_muldiv_iter.sv
module tb_muldiv_iter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o;
  logic [63:0] hi_o, lo_o;

  int checks = 0, fails = 0, cyc = 0;

  muldiv_iter dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  always #4 clk = ~clk;

  bit          m_busy = 0, m_done = 0, m_ign = 0;
  int          m_cnt = 0;
  logic [63:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  string       m_tag = "R3", p_tag = "R3";

  function automatic int msb128(input logic [127:0] v);
    int p = 0;
    for (int i = 0; i < 128; i++) if (v[i]) p = i;
    return p;
  endfunction

  task automatic model_accept(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] xa, xb, pr, q, r, ua, ub;
    bit wide = op[2], sgn = op[1], dv = op[0];
    if (wide) begin
      xa = sgn ? {{64{a[63]}}, a} : {64'b0, a};
      xb = sgn ? {{64{b[63]}}, b} : {64'b0, b};
    end else begin
      xa = sgn ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
      xb = sgn ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
    end
    if (!dv) begin
      pr = xa * xb;
      m_cnt = wide ? 6 : 4;
      p_tag = wide ? (sgn ? "R5/R6" : "R5") : (sgn ? "R4/R6" : "R4");
      if (wide) begin p_hi = pr[127:64]; p_lo = pr[63:0]; end
      else begin p_hi = {{32{pr[63]}}, pr[63:32]}; p_lo = {{32{pr[31]}}, pr[31:0]}; end
    end else if (xb == 0) begin
      m_cnt = 21;
      p_tag = "R9";
      p_lo = '1;
      p_hi = wide ? xa[63:0] : {{32{xa[31]}}, xa[31:0]};
    end else begin
      int k, pa, pb;
      ua = (xa < 0) ? -xa : xa;
      ub = (xb < 0) ? -xb : xb;
      pa = msb128(ua); pb = msb128(ub);
      k = (ua != 0 && pa >= pb) ? pa - pb + 1 : 1;
      m_cnt = 21 + ((k - 1) * 52 + 31) / 63;
      if (m_cnt > 73) m_cnt = 73;
      q = xa / xb;
      r = xa % xb;
      p_tag = sgn ? "R7/R8/R6" : "R7/R8";
      if (wide) begin p_lo = q[63:0]; p_hi = r[63:0]; end
      else begin p_lo = {{32{q[31]}}, q[31:0]}; p_hi = {{32{r[31]}}, r[31:0]}; end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_hi = '0; m_lo = '0; m_ign = 0;
    end else begin
      m_done = 0;
      m_ign = start_i && m_busy;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_hi = p_hi; m_lo = p_lo; m_tag = p_tag;
        end
      end else if (start_i) begin
        model_accept(op_i, a_i, b_i);
        m_busy = 1;
        m_tag = p_tag;
      end
    end
  end

  task automatic check64(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: reset state
      check64(!busy_o && !done_o, "R1", {62'b0, busy_o, done_o}, 64'd0);
      check64(hi_o == 0 && lo_o == 0, "R1", hi_o | lo_o, 64'd0);
    end else begin
      check64(busy_o == m_busy, m_ign ? "R2" : "R3", 64'(busy_o), 64'(m_busy));
      check64(done_o == m_done, m_ign ? "R2" : m_tag, 64'(done_o), 64'(m_done));
      check64(hi_o == m_hi, m_done ? m_tag : "R10", hi_o, m_hi);
      check64(lo_o == m_lo, m_done ? m_tag : "R10", lo_o, m_lo);
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input bit noise);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    if (noise) begin
      // R2: start while busy must be ignored
      start_i = 1'b1; op_i = 3'b101; a_i = 64'h1234; b_i = 64'h5;
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!m_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 / R6 narrow multiplies
    run_op(3'b010, 64'hFFFF_FFFF_FFFF_FFFD, 64'h7, 0);
    run_op(3'b000, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1);
    run_op(3'b010, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0);
    // R5 / R6 wide multiplies
    run_op(3'b100, '1, '1, 0);
    run_op(3'b110, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1);
    run_op(3'b110, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 0);
    // R7 / R8 divides, k extremes
    run_op(3'b101, 64'd1, 64'd1, 0);
    run_op(3'b101, 64'h8000_0000_0000_0000, 64'd1, 1);
    run_op(3'b101, 64'd5, 64'd100, 0);
    run_op(3'b101, 64'd0, 64'd7, 0);
    run_op(3'b111, 64'h8000_0000_0000_0000, '1, 0);
    run_op(3'b111, -64'sd100, 64'd7, 0);
    run_op(3'b011, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0);
    run_op(3'b011, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007, 0);
    run_op(3'b001, 64'h0000_0000_FFFF_FFFF, 64'd1, 0);
    // R9 divide by zero
    run_op(3'b101, 64'h55, 64'd0, 0);
    run_op(3'b011, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_0000_0000, 1);
    for (int n = 0; n < 200; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom} >> ($urandom % 64);
      rb = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 16 == 0) rb = '0;
      run_op(3'($urandom), ra, rb, ($urandom % 4) == 0);
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule